// File: doc/BRIEF.md
# Keyed Flash Timing Tick Generator

This block produces the timing tick that paces flash programming and erase. It picks one of three incoming clock enables: auxiliary, main or sub-main. It then divides the enables of that source by a ratio from 1 to 64 and emits a one-cycle tick every N enables. Both the source and the ratio live in a 16-bit control register on a simple peripheral bus. A companion status register holds the violation flags, the lock bit and the emergency-exit bit.

Every write must carry a key byte in its upper half, and a write with a wrong key is dropped and flagged. The control register cannot be changed while the flash reports busy; such a write is refused and raises an access-violation flag. An emergency-exit request, from either the dedicated input or the status bit, holds the divider cleared. A power-up clear does the same.

Top module: `flash_tick_gen`

## Requirements
- R1: After reset (synchronous, active-high `rst`), the control register reads 16'h9642, which is source 1 and divide field 2. The status register reads 16'h9618 while `busy` is low.
- R2: The control register is at address 16'h012A, with the divide field in bits 5:0 and the source select in bits 7:6. The status register is at 16'h012C. Both read with 8'h96 in bits 15:8 at any time, including while busy. Any other address reads 16'h0000.
- R3: The status register bits are: bit0 busy (live input), bit1 key error, bit2 access error, bit3 ready (inverse of busy), bit4 lock, bit5 emergency exit. Bits 7:6 read 0.
- R4: A write to either register whose bits 15:8 are not 8'hA5 changes nothing except that it sets the key-error flag.
- R5: A correctly keyed control write while `busy` is high leaves the control register unchanged and sets the access-error flag.
- R6: With divide field D, `tick` is high during the (D+1)-th, 2(D+1)-th, ... enable of the selected source after a restart. With D=0, every enable ticks.
- R7: A source select of 0 uses `aux_en`, 1 uses `main_en`, and 2 or 3 use `sub_en`. `tick` is never high while the selected enable is low.
- R8: While `esc_req` or the emergency-exit status bit is high, the count is held at zero and `tick` stays low.
- R9: An accepted control write suppresses `tick` in its own cycle and restarts the count from zero with the new settings.
- R10: The key-error and access-error flags stay set until a correctly keyed status write writes their bits; that write also sets lock and emergency exit from bits 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Power-up clear, synchronous, active-high |
| bus_addr | input | 16 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data, key byte in bits 15:8 |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| aux_en | input | 1 | Auxiliary clock enable |
| main_en | input | 1 | Main clock enable |
| sub_en | input | 1 | Sub-main clock enable |
| busy | input | 1 | Flash operation in progress |
| esc_req | input | 1 | Emergency-exit request, holds divider cleared |
| tick | output | 1 | Divided timing tick |

## Verification
The divider is first run with a steady enable at the reset ratio and at ratio 64, which separates an off-by-one in the terminal count from a correct wrap. Each source select is then driven with independent random patterns on all three enables, so a wrong mux leg shows up as ticks that track the wrong input. Writes are issued mid-count, with a bad key, and while busy, which separates a clean restart from a stretched first period and refused writes from accepted ones. A long mixed phase of random writes, busy and emergency pulses compares every cycle against a behavioural model.

// File: rtl/fkg_pkg.sv
package fkg_pkg;

    localparam int DATA_W = 16;
    localparam int DIV_W  = 6;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] WR_KEY = 8'hA5;
    localparam logic [BYTE_W-1:0] RD_TAG = 8'h96;

    typedef enum logic [1:0] {
        SRC_AUX  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_SUB  = 2'd2,
        SRC_SUBB = 2'd3
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [DIV_W-1:0] div;
    } cfg_t;

    typedef struct packed {
        logic emex;
        logic lock;
        logic acc_err;
        logic key_err;
    } flag_t;

    localparam cfg_t  CFG_RST  = '{src: SRC_MAIN, div: 6'd2};
    localparam flag_t FLAG_RST = '{emex: 1'b0, lock: 1'b1, acc_err: 1'b0, key_err: 1'b0};

    function automatic logic [DATA_W-1:0] pack_cfg(cfg_t c);
        return {RD_TAG, c};
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(flag_t f, logic bsy);
        return {RD_TAG, 2'b00, f.emex, f.lock, ~bsy, f.acc_err, f.key_err, bsy};
    endfunction

endpackage

// File: rtl/fkg_regs.sv
module fkg_regs
    import fkg_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h012A,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h012C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output cfg_t              cfg,
    output flag_t             flags,
    output logic              cfg_load,
    output logic [DATA_W-1:0] rdata
);

    logic key_ok, hit_ctrl, hit_stat;
    logic unused_bits;

    assign key_ok      = (wdata[DATA_W-1:DATA_W-BYTE_W] == WR_KEY);
    assign hit_ctrl    = (addr == CTRL_ADDR);
    assign hit_stat    = (addr == STAT_ADDR);
    assign cfg_load    = we && hit_ctrl && key_ok && !busy;
    assign unused_bits = ^{wdata[7:6], wdata[3], wdata[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RST;
            flags <= FLAG_RST;
        end else if (we && (hit_ctrl || hit_stat)) begin
            if (!key_ok) begin
                flags.key_err <= 1'b1;
            end else if (hit_ctrl) begin
                if (busy) flags.acc_err <= 1'b1;
                else      cfg <= cfg_t'(wdata[BYTE_W-1:0]);
            end else begin
                flags.key_err <= wdata[1];
                flags.acc_err <= wdata[2];
                flags.lock    <= wdata[4];
                flags.emex    <= wdata[5];
            end
        end
    end

    always_comb begin
        if (hit_ctrl)      rdata = pack_cfg(cfg);
        else if (hit_stat) rdata = pack_stat(flags, busy);
        else               rdata = '0;
    end

endmodule

// File: rtl/fkg_src_mux.sv
module fkg_src_mux
    import fkg_pkg::*;
(
    input  src_e sel,
    input  logic aux_en,
    input  logic main_en,
    input  logic sub_en,
    output logic src_en
);

    always_comb begin
        unique case (sel)
            SRC_AUX:  src_en = aux_en;
            SRC_MAIN: src_en = main_en;
            default:  src_en = sub_en;
        endcase
    end

endmodule

// File: rtl/fkg_div.sv
module fkg_div
    import fkg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic [DIV_W-1:0] cnt,
    output logic             tick
);

    logic at_end;

    assign at_end = (cnt == div);
    assign tick   = en && at_end && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/flash_tick_gen.sv
module flash_tick_gen
    import fkg_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h012A,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h012C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              aux_en,
    input  logic              main_en,
    input  logic              sub_en,
    input  logic              busy,
    input  logic              esc_req,
    output logic              tick
);

    cfg_t             cfg;
    flag_t            flags;
    logic             cfg_load;
    logic             src_en;
    logic             restart;
    logic [DIV_W-1:0] cnt;

    fkg_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .busy    (busy),
        .cfg     (cfg),
        .flags   (flags),
        .cfg_load(cfg_load),
        .rdata   (bus_rdata)
    );

    fkg_src_mux u_mux (
        .sel    (cfg.src),
        .aux_en (aux_en),
        .main_en(main_en),
        .sub_en (sub_en),
        .src_en (src_en)
    );

    assign restart = esc_req || flags.emex || cfg_load;

    fkg_div u_div (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .en     (src_en),
        .div    (cfg.div),
        .cnt    (cnt),
        .tick   (tick)
    );

endmodule

// File: rtl/fkg_checker.sv
module fkg_checker
    import fkg_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h012A,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h012C
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              busy,
    input logic              esc_req,
    input logic              tick,
    input logic              src_en,
    input logic [DIV_W-1:0]  cnt,
    input cfg_t              cfg,
    input flag_t             flags
);

    logic good_key;
    assign good_key = (bus_wdata[15:8] == WR_KEY);

    AST_READ_TAG: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CTRL_ADDR || bus_addr == STAT_ADDR) |-> bus_rdata[15:8] == RD_TAG); // R2

    AST_KEY_REJECT: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == CTRL_ADDR || bus_addr == STAT_ADDR) && !good_key)
        |=> flags.key_err && $stable(cfg)); // R4

    AST_BUSY_VIOLATION: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CTRL_ADDR && good_key && busy)
        |=> flags.acc_err && $stable(cfg)); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= cfg.div); // R6

    AST_TICK_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        tick |-> src_en); // R7

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (esc_req || flags.emex) |-> !tick); // R8

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == CTRL_ADDR && good_key && !busy) |=> cnt == '0); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.key_err && !(bus_we && bus_addr == STAT_ADDR && good_key))
        |=> flags.key_err); // R10

endmodule

bind flash_tick_gen fkg_checker #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy     (busy),
    .esc_req  (esc_req),
    .tick     (tick),
    .src_en   (src_en),
    .cnt      (cnt),
    .cfg      (cfg),
    .flags    (flags)
);

// File: tb/tb_flash_tick_gen.sv
module tb_flash_tick_gen;

    localparam logic [15:0] A_CTRL = 16'h012A;
    localparam logic [15:0] A_STAT = 16'h012C;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, we, aux, mn, sb, busy, esc;
    logic [15:0] addr, wdata;
    logic [15:0] rdata;
    logic        tick;

    flash_tick_gen dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .aux_en(aux), .main_en(mn), .sub_en(sb),
        .busy(busy), .esc_req(esc), .tick(tick)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int m_div, m_sel, m_cnt;
    bit m_kerr, m_aerr, m_lock, m_emex;

    function automatic bit m_en();
        if (m_sel == 0) return aux;
        if (m_sel == 1) return mn;
        return sb;
    endfunction

    function automatic bit m_key();
        return wdata[15:8] == 8'hA5;
    endfunction

    function automatic bit m_load();
        return we && addr == A_CTRL && m_key() && !busy;
    endfunction

    function automatic bit m_tick();
        return m_en() && m_cnt == m_div && !(esc || m_emex || m_load());
    endfunction

    function automatic logic [15:0] m_rd();
        if (addr == A_CTRL) return {8'h96, 2'(m_sel), 6'(m_div)};
        if (addr == A_STAT) return {8'h96, 2'b00, m_emex, m_lock, ~busy, m_aerr, m_kerr, busy};
        return 16'h0000;
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        int n_div, n_sel, n_cnt;
        bit n_kerr, n_aerr, n_lock, n_emex;
        #2;
        chk(tag, "tick", {15'd0, tick}, {15'd0, m_tick()});
        chk(tag, "rdata", rdata, m_rd());
        n_div = m_div; n_sel = m_sel; n_cnt = m_cnt;
        n_kerr = m_kerr; n_aerr = m_aerr; n_lock = m_lock; n_emex = m_emex;
        if (rst) begin
            n_div = 2; n_sel = 1; n_cnt = 0;
            n_kerr = 0; n_aerr = 0; n_lock = 1; n_emex = 0;
        end else begin
            if (esc || m_emex || m_load()) n_cnt = 0;
            else if (m_en()) n_cnt = (m_cnt == m_div) ? 0 : m_cnt + 1;
            if (we && (addr == A_CTRL || addr == A_STAT)) begin
                if (!m_key()) n_kerr = 1;
                else if (addr == A_CTRL) begin
                    if (busy) n_aerr = 1;
                    else begin n_div = int'(wdata[5:0]); n_sel = int'(wdata[7:6]); end
                end else begin
                    n_kerr = wdata[1]; n_aerr = wdata[2]; n_lock = wdata[4]; n_emex = wdata[5];
                end
            end
        end
        @(posedge clk);
        m_div = n_div; m_sel = n_sel; m_cnt = n_cnt;
        m_kerr = n_kerr; m_aerr = n_aerr; m_lock = n_lock; m_emex = n_emex;
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic wr(input string tag, input logic [15:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        step(tag);
        we = 1'b0; wdata = 16'h0000;
    endtask

    task automatic rand_en(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            aux = 1'($urandom % 2); mn = 1'($urandom % 2); sb = 1'($urandom % 2);
            step(tag);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        rst = 1'b1; we = 1'b0; aux = 1'b0; mn = 1'b0; sb = 1'b0;
        busy = 1'b0; esc = 1'b0; addr = 16'h0000; wdata = 16'h0000;
        m_div = 0; m_sel = 0; m_cnt = 0; m_kerr = 0; m_aerr = 0; m_lock = 0; m_emex = 0;
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        step("R1");
        rst = 1'b0;

        addr = A_CTRL; #2; chk("R1", "ctrl reset", rdata, 16'h9642); #0; step("R1");
        addr = A_STAT; #2; chk("R1", "stat reset", rdata, 16'h9618); #0; step("R3");
        addr = 16'h0100; step("R2");

        addr = A_CTRL; mn = 1'b1;
        idle("R6", 12);

        wr("R9", A_CTRL, 16'hA500);
        aux = 1'b1; idle("R6", 4);
        rand_en("R7", 24);
        wr("R7", A_CTRL, 16'hA584); rand_en("R7", 40);
        wr("R7", A_CTRL, 16'hA5C1); rand_en("R7", 30);
        wr("R7", A_CTRL, 16'hA545); rand_en("R7", 40);

        wr("R6", A_CTRL, 16'hA5BF);
        aux = 1'b0; mn = 1'b0; sb = 1'b1;
        idle("R6", 140);

        wr("R9", A_CTRL, 16'hA583); idle("R9", 2);
        wr("R9", A_CTRL, 16'hA583); idle("R9", 6);

        wr("R4", A_CTRL, 16'h5A11);
        addr = A_CTRL; step("R4");
        addr = A_STAT; step("R4");

        busy = 1'b1;
        wr("R5", A_CTRL, 16'hA502);
        addr = A_CTRL; step("R2");
        addr = A_STAT; step("R5");
        busy = 1'b0;

        addr = A_STAT; idle("R10", 3);
        wr("R10", A_STAT, 16'hA510); step("R10");
        wr("R4", A_STAT, 16'h0000); step("R10");
        wr("R10", A_STAT, 16'hA506); step("R10");
        wr("R10", A_STAT, 16'hA510); step("R10");

        addr = A_CTRL; sb = 1'b1;
        esc = 1'b1; idle("R8", 5);
        esc = 1'b0; idle("R8", 8);
        wr("R8", A_STAT, 16'hA530); addr = A_STAT; idle("R8", 10);
        wr("R8", A_STAT, 16'hA510); idle("R8", 10);

        for (int i = 0; i < 400; i++) begin
            int pick;
            aux = 1'($urandom % 2); mn = 1'($urandom % 2); sb = 1'($urandom % 3 != 0);
            busy = ($urandom % 5 == 0);
            esc  = ($urandom % 20 == 0);
            we   = ($urandom % 8 == 0);
            pick = $urandom % 3;
            addr = (pick == 0) ? A_CTRL : (pick == 1) ? A_STAT : 16'h0128;
            wdata = {(($urandom % 10) < 7) ? 8'hA5 : 8'($urandom), 8'($urandom)};
            if (addr == A_STAT && $urandom % 2 == 0) wdata[5] = 1'b0;
            step("R6");
        end
        we = 1'b0; esc = 1'b0; busy = 1'b0;
        idle("R6", 4);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R6: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule